// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block supervises running software with a counter that must be refreshed on time. A 6-bit control register holds a 3-bit period code, an output steering bit, a stage-one enable and a sticky monitor flag. The count advances once per millisecond tick, and a prescaler makes that tick from the clock. Software refreshes the count with a kick pulse or with any write to the control register.

If the period runs out, stage one begins. When it is enabled, the block raises a held interrupt on either the NMI or the INIT output, as the steering bit selects, and it sets the monitor flag. A grace interval follows. If no refresh comes during it, stage two drives a system reset pulse of fixed length. That reset also turns off the stage-one enable. When the pulse ends, counting starts again from zero.

For simulation the tick divisor, the grace interval and the pulse length are parameters, so the periods can be made short.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, reg_rdata is 0 and nmi_o, init_o and sys_rst_o are all 0.
- R2: Control register layout. Bits [2:0] are the period code, bit 3 is the steering select (0 = NMI, 1 = INIT), bit 4 is the stage-one enable and bit 5 is the monitor flag. A write stores bits [4:0], and reading returns the value last written to them.
- R3: The period codes 0 to 7 select 250, 500, 1000, 8000, 32000, 64000, 128000 and 256000 ms. One ms is CLK_PER_MS cycles. Expiry happens exactly period×CLK_PER_MS cycles after the clock edge that took the last refresh, and never earlier.
- R4: When the period expires with the enable at 1, the selected stage-one output goes high and stays high, and the monitor bit becomes 1.
- R5: When the period expires with the enable at 0, no stage-one output asserts and the monitor bit is not set.
- R6: Once set, the monitor bit stays 1. Only a write with bit 5 = 0 clears it, and a write with bit 5 = 1 never sets it.
- R7: nmi_o and init_o are never high together. The output that asserts is the one that bit 3 selects.
- R8: sys_rst_o rises STAGE2_MS×CLK_PER_MS cycles after expiry unless a refresh comes first. This happens whether or not the enable is set.
- R9: A kick or a register write restarts the count from zero, drops the stage-one output and cancels a pending stage-two reset.
- R10: sys_rst_o stays high for exactly RST_PULSE cycles. When it rises, the enable reads 0, the stage-one output is low, and the period code, steering and monitor bits are kept. Counting restarts from zero at the end of the pulse.
- R11: While sys_rst_o is high, kicks and register writes are ignored.
- R12: Writing a new period code in the middle of a count restarts the count, so the new period is measured from that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hard reset |
| kick | input | 1 | Refresh pulse, one cycle |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 6 | Control register write data |
| reg_rdata | output | 6 | Control register contents |
| nmi_o | output | 1 | Stage-one interrupt, NMI route |
| init_o | output | 1 | Stage-one interrupt, INIT route |
| sys_rst_o | output | 1 | Stage-two system reset pulse |

## Verification
The assertions check several rules on every cycle. The two stage-one outputs are never high together. The monitor flag stays set until a clearing write. A refresh always drops the stage-one output and keeps the reset from starting. A stage-one output never rises earlier than the coded period, and the stage-one output only rises while the enable is set. Written fields read back. Register contents do not change during the reset pulse, and the pulse has the right length. The exact expiry cycle for each period code, the grace delay before the reset, and the steering outcome come from the bench scenarios. So do the restart after the pulse and the effect of a period change in the middle of a count.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   localparam int CTRL_W    = 6;
   localparam int TC_LSB    = 0;
   localparam int STEER_BIT = 3;
   localparam int EN_BIT    = 4;
   localparam int MON_BIT   = 5;

   localparam int unsigned MAX_PERIOD_MS = 256000;

   typedef enum logic [1:0] {
      ST_COUNT = 2'd0,
      ST_GRACE = 2'd1,
      ST_PULSE = 2'd2
   } wd_state_e;

   function automatic int unsigned code_to_ms(input logic [2:0] code);
      case (code)
         3'd0:    return 250;
         3'd1:    return 500;
         3'd2:    return 1000;
         3'd3:    return 8000;
         3'd4:    return 32000;
         3'd5:    return 64000;
         3'd6:    return 128000;
         default: return 256000;
      endcase
   endfunction

endpackage

// File: rtl/wdog_tick.sv
module wdog_tick #(
   parameter int CLK_PER_MS = 50000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   localparam int PW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
   localparam logic [PW-1:0] LAST = PW'(CLK_PER_MS - 1);

   logic [PW-1:0] pcnt;

   assign tick = (pcnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt <= '0;
      end else if (restart || tick) begin
         pcnt <= '0;
      end else begin
         pcnt <= pcnt + 1'b1;
      end
   end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wdata,
   input  logic              set_mon,
   input  logic              fire,
   output logic [2:0]        tc,
   output logic              steer,
   output logic              en,
   output logic [CTRL_W-1:0] rdata
);
   logic mon;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tc    <= 3'd0;
         steer <= 1'b0;
         en    <= 1'b0;
         mon   <= 1'b0;
      end else begin
         if (wr_en) begin
            tc    <= wdata[TC_LSB+2:TC_LSB];
            steer <= wdata[STEER_BIT];
            en    <= wdata[EN_BIT];
            if (!wdata[MON_BIT]) mon <= 1'b0;
         end
         if (set_mon) mon <= 1'b1;
         if (fire)    en  <= 1'b0;
      end
   end

   always_comb begin
      rdata                     = '0;
      rdata[TC_LSB+2:TC_LSB]    = tc;
      rdata[STEER_BIT]          = steer;
      rdata[EN_BIT]             = en;
      rdata[MON_BIT]            = mon;
   end
endmodule

// File: rtl/wdog_core.sv
module wdog_core
   import wdog_pkg::*;
#(
   parameter int STAGE2_MS = 250,
   parameter int RST_PULSE = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       reload,
   input  logic [2:0] tc,
   input  logic       en,
   output logic       restart,
   output logic       set_mon,
   output logic       fire,
   output logic       s1_act,
   output logic       in_pulse
);
   localparam int unsigned SPAN = (MAX_PERIOD_MS > STAGE2_MS) ? MAX_PERIOD_MS : STAGE2_MS;
   localparam int MS_W = $clog2(SPAN + 1);
   localparam int RW   = (RST_PULSE > 1) ? $clog2(RST_PULSE) : 1;
   localparam logic [MS_W-1:0] GRACE_LAST = MS_W'(STAGE2_MS - 1);
   localparam logic [RW-1:0]   PULSE_LAST = RW'(RST_PULSE - 1);

   wd_state_e       state;
   logic [MS_W-1:0] mcnt;
   logic [RW-1:0]   rcnt;
   logic [MS_W-1:0] limit;
   logic            expire;
   logic            pulse_end;

   assign limit     = MS_W'(code_to_ms(tc));
   assign expire    = (state == ST_COUNT) && !reload && tick && (mcnt == limit - 1'b1);
   assign fire      = (state == ST_GRACE) && !reload && tick && (mcnt == GRACE_LAST);
   assign pulse_end = (state == ST_PULSE) && (rcnt == PULSE_LAST);
   assign restart   = reload || pulse_end;
   assign set_mon   = expire && en;
   assign in_pulse  = (state == ST_PULSE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_COUNT;
         mcnt   <= '0;
         rcnt   <= '0;
         s1_act <= 1'b0;
      end else if (reload) begin
         state  <= ST_COUNT;
         mcnt   <= '0;
         s1_act <= 1'b0;
      end else begin
         case (state)
            ST_COUNT: begin
               if (expire) begin
                  state  <= ST_GRACE;
                  mcnt   <= '0;
                  s1_act <= en;
               end else if (tick) begin
                  mcnt <= mcnt + 1'b1;
               end
            end
            ST_GRACE: begin
               if (fire) begin
                  state  <= ST_PULSE;
                  mcnt   <= '0;
                  rcnt   <= '0;
                  s1_act <= 1'b0;
               end else if (tick) begin
                  mcnt <= mcnt + 1'b1;
               end
            end
            ST_PULSE: begin
               if (pulse_end) begin
                  state <= ST_COUNT;
                  mcnt  <= '0;
               end else begin
                  rcnt <= rcnt + 1'b1;
               end
            end
            default: state <= ST_COUNT;
         endcase
      end
   end
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
   import wdog_pkg::*;
#(
   parameter int CLK_PER_MS = 50000,
   parameter int STAGE2_MS  = 250,
   parameter int RST_PULSE  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              kick,
   input  logic              reg_wr,
   input  logic [CTRL_W-1:0] reg_wdata,
   output logic [CTRL_W-1:0] reg_rdata,
   output logic              nmi_o,
   output logic              init_o,
   output logic              sys_rst_o
);
   if (CLK_PER_MS < 1) begin : g_bad_div
      $error("CLK_PER_MS must be at least 1");
   end
   if (STAGE2_MS < 1) begin : g_bad_grace
      $error("STAGE2_MS must be at least 1");
   end
   if (RST_PULSE < 1) begin : g_bad_pulse
      $error("RST_PULSE must be at least 1");
   end

   logic       tick, restart, set_mon, fire, s1_act, in_pulse;
   logic       reload, wr_ok;
   logic [2:0] tc;
   logic       steer, en;

   assign wr_ok  = reg_wr && !in_pulse;
   assign reload = (kick || reg_wr) && !in_pulse;

   wdog_tick #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .tick    (tick)
   );

   wdog_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_ok),
      .wdata   (reg_wdata),
      .set_mon (set_mon),
      .fire    (fire),
      .tc      (tc),
      .steer   (steer),
      .en      (en),
      .rdata   (reg_rdata)
   );

   wdog_core #(.STAGE2_MS(STAGE2_MS), .RST_PULSE(RST_PULSE)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .reload   (reload),
      .tc       (tc),
      .en       (en),
      .restart  (restart),
      .set_mon  (set_mon),
      .fire     (fire),
      .s1_act   (s1_act),
      .in_pulse (in_pulse)
   );

   assign nmi_o     = s1_act && !steer;
   assign init_o    = s1_act && steer;
   assign sys_rst_o = in_pulse;
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
   import wdog_pkg::*;
#(
   parameter int CLK_PER_MS = 50000,
   parameter int STAGE2_MS  = 250,
   parameter int RST_PULSE  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              kick,
   input logic              reg_wr,
   input logic [CTRL_W-1:0] reg_wdata,
   input logic [CTRL_W-1:0] reg_rdata,
   input logic              nmi_o,
   input logic              init_o,
   input logic              sys_rst_o
);
   logic [63:0] since;
   logic [31:0] plen;
   logic [63:0] min_cyc;

   assign min_cyc = 64'(code_to_ms(reg_rdata[2:0])) * 64'(CLK_PER_MS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since <= '0;
         plen  <= '0;
      end else begin
         if (((kick || reg_wr) && !sys_rst_o) || sys_rst_o) since <= '0;
         else if (since != '1) since <= since + 1'b1;
         if (sys_rst_o) plen <= plen + 1'b1;
         else           plen <= '0;
      end
   end

   // R7
   p_steer_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(nmi_o && init_o));

   // R6
   p_mon_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[MON_BIT] && !(reg_wr && !sys_rst_o && !reg_wdata[MON_BIT]))
      |=> reg_rdata[MON_BIT]);

   // R4 R5
   p_s1_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nmi_o || init_o) |-> ($past(reg_rdata[EN_BIT]) && reg_rdata[MON_BIT]));

   // R3
   p_no_early_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nmi_o || init_o) |-> (since >= min_cyc));

   // R9
   p_refresh_cancels_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((kick || reg_wr) && !sys_rst_o) |=> (!nmi_o && !init_o && !sys_rst_o));

   // R10
   p_fire_clears_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst_o) |-> (!reg_rdata[EN_BIT] && !nmi_o && !init_o));

   // R10
   p_pulse_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sys_rst_o) |-> (plen == 32'(RST_PULSE)));

   // R11
   p_pulse_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_o |=> $stable(reg_rdata));

   // R2
   p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !sys_rst_o) |=> (reg_rdata[4:0] == $past(reg_wdata[4:0])));

endmodule

bind wdog_two_stage wdog_chk #(
   .CLK_PER_MS (CLK_PER_MS),
   .STAGE2_MS  (STAGE2_MS),
   .RST_PULSE  (RST_PULSE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .kick      (kick),
   .reg_wr    (reg_wr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .nmi_o     (nmi_o),
   .init_o    (init_o),
   .sys_rst_o (sys_rst_o)
);

// File: tb/wdog_two_stage_tb_top.sv
`timescale 1ns/1ps
module wdog_two_stage_tb_top;
   localparam int C  = 2;
   localparam int S2 = 250;
   localparam int P  = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       kick = 1'b0;
   logic       reg_wr = 1'b0;
   logic [5:0] reg_wdata = '0;
   logic [5:0] reg_rdata;
   logic       nmi_o, init_o, sys_rst_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   wdog_two_stage #(.CLK_PER_MS(C), .STAGE2_MS(S2), .RST_PULSE(P)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .kick      (kick),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .nmi_o     (nmi_o),
      .init_o    (init_o),
      .sys_rst_o (sys_rst_o)
   );

   // {exp_init, exp_nmi, ctrl[5:0]}
   localparam logic [7:0] VEC [4] = '{8'h50, 8'h99, 8'h02, 8'h98};

   function automatic int per_ms(input logic [2:0] c);
      case (c)
         3'd0: return 250;   3'd1: return 500;
         3'd2: return 1000;  3'd3: return 8000;
         3'd4: return 32000; 3'd5: return 64000;
         3'd6: return 128000;
         default: return 256000;
      endcase
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [5:0] d);
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic kick_t();
      kick = 1'b1;
      @(negedge clk);
      kick = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      wait_n(3);
      chk({29'd0, nmi_o, init_o, sys_rst_o}, 0, "R1 outputs in reset");
      rst_n = 1'b1;
      wait_n(1);
      chk(32'(reg_rdata), 0, "R1 rdata after reset");
      chk({29'd0, nmi_o, init_o, sys_rst_o}, 0, "R1 outputs after reset");

      // R2 readback of every code
      for (int i = 0; i < 8; i++) begin
         wr(6'(i));
         chk(32'(reg_rdata), 32'(i), "R2 code readback");
      end
      wr(6'h3F);
      chk(32'(reg_rdata), 32'h1F, "R2 R6 write of monitor bit 1 does not set it");

      // vector table
      for (int v = 0; v < 4; v++) begin
         logic [5:0] ctl;
         int cyc;
         ctl = VEC[v][5:0];
         cyc = per_ms(ctl[2:0]) * C;
         wr(ctl);
         chk(32'(reg_rdata), 32'(ctl[4:0]), "R2 table readback");
         wait_n(cyc - 1);
         chk({30'd0, init_o, nmi_o}, 0, "R3 no early expiry");
         wait_n(1);
         chk({30'd0, init_o, nmi_o}, 32'(VEC[v][7:6]), "R4 R5 R7 stage-one output");
         chk(32'(reg_rdata[5]), 32'(ctl[4]), "R4 R5 monitor bit");
         kick_t();
         chk({30'd0, init_o, nmi_o}, 0, "R9 kick drops stage one");
         wait_n(S2 * C + 5);
         chk(32'(sys_rst_o), 0, "R9 kick cancels stage two");
      end

      // stage two timing and the reset pulse
      wr(6'h10);
      wait_n(250 * C);
      chk(32'(nmi_o), 1, "R4 nmi at expiry");
      chk(32'(reg_rdata), 32'h30, "R4 monitor and enable");
      wait_n(S2 * C - 1);
      chk(32'(sys_rst_o), 0, "R8 no early reset");
      wait_n(1);
      chk(32'(sys_rst_o), 1, "R8 reset at grace end");
      chk(32'(reg_rdata), 32'h20, "R10 enable cleared, other fields kept");
      chk(32'(nmi_o), 0, "R10 nmi dropped");
      wr(6'h13);
      kick_t();
      chk(32'(reg_rdata), 32'h20, "R11 write ignored during pulse");
      chk(32'(sys_rst_o), 1, "R11 kick ignored during pulse");
      wait_n(1);
      chk(32'(sys_rst_o), 1, "R10 pulse still high");
      wait_n(1);
      chk(32'(sys_rst_o), 0, "R10 pulse length");
      wait_n(250 * C + S2 * C - 1);
      chk({29'd0, nmi_o, init_o, sys_rst_o}, 0, "R10 R5 restart with enable off");
      wait_n(1);
      chk(32'(sys_rst_o), 1, "R8 R10 reset after restart with enable off");
      wait_n(P);
      chk(32'(sys_rst_o), 0, "R10 second pulse ends");

      // monitor stickiness
      chk(32'(reg_rdata), 32'h20, "R6 monitor held after pulse");
      wr(6'h23);
      chk(32'(reg_rdata), 32'h23, "R6 write with bit 5 = 1 keeps monitor");
      wr(6'h03);
      chk(32'(reg_rdata), 32'h03, "R6 write with bit 5 = 0 clears monitor");

      // period change mid-count
      wr(6'h10);
      wait_n(400);
      wr(6'h11);
      wait_n(500 * C - 1);
      chk(32'(nmi_o), 0, "R12 restart on code change");
      wait_n(1);
      chk(32'(nmi_o), 1, "R12 new period measured from write");
      kick_t();

      // kick during grace
      wr(6'h10);
      wait_n(250 * C);
      chk(32'(nmi_o), 1, "R4 nmi before grace kick");
      wait_n(300);
      kick_t();
      chk({29'd0, nmi_o, init_o, sys_rst_o}, 0, "R9 grace kick clears outputs");
      wait_n(199);
      chk(32'(sys_rst_o), 0, "R9 pending reset cancelled");

      // long code 3 with INIT steering off
      wr(6'h13);
      wait_n(8000 * C - 1);
      chk({30'd0, init_o, nmi_o}, 0, "R3 code 3 not early");
      wait_n(1);
      chk({30'd0, init_o, nmi_o}, 1, "R3 code 3 expiry");
      kick_t();

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule